// File: doc/BRIEF.md
# Up-Counting Tick Timer with Fractional Period Correction

This block is a general-purpose timer for a slow functional clock. A counter counts upward, optionally through a power-of-two prescaler. When it passes its all-ones value it raises an overflow event. It then either reloads from a load register or stops. A compare register flags a match. A synchronised capture input latches the counter on a chosen edge. Three event sources share one status register, which software clears by writing ones. Separate enable masks drive a level interrupt and a level wake output. A registered trigger pulse marks overflows, or overflows and matches.

For operating-system tick generation, an optional correction stage keeps a signed accumulator. At each auto-reload overflow it picks the period N or N+1 from two programmed signed increments. The average tick rate then comes out exact even when the clock rate is not a multiple of the tick rate. Builds without the stage ignore the increment registers.

Software programs the load value 2^CW − N and seeds the counter with the same value, then sets the start bit. A soft-reset command returns every register to its reset value. A read-only bit shows when that reset has finished.

Top module: `gp_tick_timer`

## Requirements
- R1: After reset every register reads 0, except the reset-done register, whose bit 0 reads 1; irq, wake and trig are low.
- R2: Register word addresses: 0 control, 1 system config, 2 reset-done, 3 status, 4 irq enable, 5 wake enable, 6 counter, 7 load, 8 compare, 9 capture, 10 positive increment, 11 negative increment, 12 accumulator. Control bits: 0 start, 1 auto-reload, 4:2 prescale exponent p, 5 prescale enable, 6 compare enable, 9:8 capture mode, 11:10 trigger mode. Bit 7 and bits above 11 read 0.
- R3: With start and auto-reload set, prescaler off, counter and load both set to 2^32 − N, an overflow occurs every N clocks.
- R4: With auto-reload clear, an overflow sets the counter to 0, clears the start bit and sets status bit 1.
- R5: With the prescaler enabled, the counter advances once every 2^(p+1) clocks, so the overflow period is N·2^(p+1).
- R6: With compare enabled, status bit 0 sets when the running counter reaches the compare value. With compare disabled it never sets.
- R7: Capture mode 00 ignores the input, 01 reacts to rising edges, 10 to falling edges and 11 to both. A selected edge copies the counter into the capture register and sets status bit 2.
- R8: Status bits are cleared by writing 1 to them; other bits keep their value. irq (wake) is high one clock after any status bit is set whose irq-enable (wake-enable) bit is also set.
- R9: Writing 1 to bit 1 of the system config register resets all registers on the next clock. During that clock, bit 0 of the reset-done register reads 0. Afterwards it reads 1 and the config bit reads 0.
- R10: At each auto-reload overflow, if accumulator + negative increment ≥ 0 the accumulator takes that sum and the next period is N. Otherwise the positive increment is added and the next period is N+1.
- R11: Without the correction option, the increment registers read 0 and every period stays N whatever they were written with.
- R12: Trigger mode 01 gives a one-clock trig pulse per overflow. Mode 10 gives one per overflow and one per match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, one clock after the address |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | Level wake request |
| trig | output | 1 | Event trigger pulse |

## Verification
Overflow spacing is measured for every period N from 1 to 6 and for each prescale exponent 0 to 7. This tells apart off-by-one errors in the reload and in the divider phase. Five increment pairs (mixed sign, both positive, both negative, and a realistic millisecond pair) exercise both branches of the correction. The measured period sequence is compared with a bench model, which separates a wrong sign test from a wrong reload choice. Every capture mode is swept against both edge directions. Status clearing is tried one bit at a time, so a write that clears too much shows up.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  localparam int ADDR_W = 4;
  localparam int PTV_W  = 3;
  localparam int EV_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SYSCFG = 4'd1;
  localparam logic [ADDR_W-1:0] A_RSTAT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd3;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_WAKEEN = 4'd5;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_LOAD   = 4'd7;
  localparam logic [ADDR_W-1:0] A_MATCH  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAPT   = 4'd9;
  localparam logic [ADDR_W-1:0] A_POSINC = 4'd10;
  localparam logic [ADDR_W-1:0] A_NEGINC = 4'd11;
  localparam logic [ADDR_W-1:0] A_ACCUM  = 4'd12;

  // event bit positions shared by status and both enable masks
  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_CAPT  = 2;

  localparam logic [1:0] TRG_OVF  = 2'b01;
  localparam logic [1:0] TRG_BOTH = 2'b10;

  typedef struct packed {
    logic [1:0]       trg;
    logic [1:0]       capm;
    logic             rsv;
    logic             cmp;
    logic             pre;
    logic [PTV_W-1:0] ptv;
    logic             ar;
    logic             st;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gtt_prescale.sv
module gtt_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             run,
  input  logic             restart,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int DIV_W = 1 << PTV_W;
  localparam logic [DIV_W-1:0] ONES = '1;
  localparam logic [PTV_W-1:0] TOP_SH = PTV_W'(DIV_W - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = ONES >> (TOP_SH - ptv);
  assign tick = run && !restart && (!pre_en || ((div_q & mask) == mask));

  always_ff @(posedge clk) begin
    if (clr || !run || restart) div_q <= '0;
    else if (tick)              div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  // R5: a divided tick is never followed by another on the next clock
  p_prescale_gap_r5: assert property (@(posedge clk) disable iff (clr)
    (tick && pre_en) |=> (!tick || !pre_en));
endmodule

// File: rtl/gtt_capture.sv
module gtt_capture (
  input  logic       clk,
  input  logic       clr,
  input  logic       cap_in,
  input  logic [1:0] mode,
  output logic       evt
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (clr) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= cap_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q && !prev_q;
  assign fall = !s2_q && prev_q;
  assign evt  = (mode[0] && rise) || (mode[1] && fall);
endmodule

// File: rtl/gtt_accum.sv
module gtt_accum #(
  parameter int CW     = 32,
  parameter bit ACC_EN = 1'b1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_pos,
  input  logic          wr_neg,
  input  logic          wr_acc,
  input  logic [CW-1:0] wdata,
  input  logic          step,
  output logic          long_sel,
  output logic [CW-1:0] pos_q,
  output logic [CW-1:0] neg_q,
  output logic [CW-1:0] acc_q
);
  generate
    if (ACC_EN) begin : g_acc
      logic [CW-1:0] pos_r, neg_r, acc_r, sum;

      assign sum      = acc_r + neg_r;
      assign long_sel = sum[CW-1];
      assign pos_q    = pos_r;
      assign neg_q    = neg_r;
      assign acc_q    = acc_r;

      always_ff @(posedge clk) begin
        if (clr) begin
          pos_r <= '0;
          neg_r <= '0;
          acc_r <= '0;
        end else begin
          if (wr_pos) pos_r <= wdata;
          if (wr_neg) neg_r <= wdata;
          if (wr_acc)    acc_r <= wdata;
          else if (step) acc_r <= long_sel ? (acc_r + pos_r) : sum;
        end
      end

      // R10: taking the normal period never leaves the accumulator negative
      p_short_nonneg_r10: assert property (@(posedge clk) disable iff (clr)
        (step && !long_sel && !wr_acc) |=> !acc_r[CW-1]);
    end else begin : g_none
      logic unused_acc_in;
      assign unused_acc_in = ^{clk, clr, wr_pos, wr_neg, wr_acc, wdata, step};
      assign long_sel = 1'b0;
      assign pos_q    = '0;
      assign neg_q    = '0;
      assign acc_q    = '0;
    end
  endgenerate
endmodule

// File: rtl/gp_tick_timer.sv
module gp_tick_timer
  import gtt_pkg::*;
#(
  parameter int CW     = 32,
  parameter bit ACC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  input  logic              cap_in,
  output logic              irq,
  output logic              wake,
  output logic              trig
);
  logic          clr, srst_q;
  ctrl_t         ctrl_q, ctrl_wr;
  logic [EV_W-1:0] stat_q, ien_q, wen_q, ev_now, clr_mask;
  logic [CW-1:0] cnt_q, load_q, match_q, capt_q;
  logic [CW-1:0] cnt_nx, reload_val;
  logic [CW-1:0] pos_q, neg_q, acc_q;
  logic tick, ovf_evt, mat_evt, cap_evt, long_sel;
  logic wr_ctrl, wr_sys, wr_stat, wr_ien, wr_wen, wr_count, wr_load, wr_match;
  logic wr_pos, wr_neg, wr_acc;

  assign clr = rst || srst_q;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_sys   = bus_wr && (bus_addr == A_SYSCFG);
  assign wr_stat  = bus_wr && (bus_addr == A_STATUS);
  assign wr_ien   = bus_wr && (bus_addr == A_IRQEN);
  assign wr_wen   = bus_wr && (bus_addr == A_WAKEEN);
  assign wr_count = bus_wr && (bus_addr == A_COUNT);
  assign wr_load  = bus_wr && (bus_addr == A_LOAD);
  assign wr_match = bus_wr && (bus_addr == A_MATCH);
  assign wr_pos   = bus_wr && (bus_addr == A_POSINC);
  assign wr_neg   = bus_wr && (bus_addr == A_NEGINC);
  assign wr_acc   = bus_wr && (bus_addr == A_ACCUM);

  always_comb begin
    ctrl_wr     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    ctrl_wr.rsv = 1'b0;
  end

  // soft reset request: self-clearing, only the hard reset clears it
  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= !srst_q && wr_sys && bus_wdata[1];
  end

  gtt_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk     (clk),
    .clr     (clr),
    .run     (ctrl_q.st),
    .restart (wr_count),
    .pre_en  (ctrl_q.pre),
    .ptv     (ctrl_q.ptv),
    .tick    (tick)
  );

  gtt_capture u_cap (
    .clk    (clk),
    .clr    (clr),
    .cap_in (cap_in),
    .mode   (ctrl_q.capm),
    .evt    (cap_evt)
  );

  gtt_accum #(.CW(CW), .ACC_EN(ACC_EN)) u_acc (
    .clk      (clk),
    .clr      (clr),
    .wr_pos   (wr_pos),
    .wr_neg   (wr_neg),
    .wr_acc   (wr_acc),
    .wdata    (bus_wdata),
    .step     (ovf_evt && ctrl_q.ar),
    .long_sel (long_sel),
    .pos_q    (pos_q),
    .neg_q    (neg_q),
    .acc_q    (acc_q)
  );

  assign ovf_evt    = tick && (cnt_q == '1);
  assign reload_val = long_sel ? (load_q - 1'b1) : load_q;

  always_comb begin
    if (wr_count)     cnt_nx = bus_wdata;
    else if (ovf_evt) cnt_nx = ctrl_q.ar ? reload_val : '0;
    else if (tick)    cnt_nx = cnt_q + 1'b1;
    else              cnt_nx = cnt_q;
  end

  assign mat_evt  = ctrl_q.cmp && tick && (cnt_nx == match_q);
  assign ev_now   = {cap_evt, ovf_evt, mat_evt};
  assign clr_mask = wr_stat ? bus_wdata[EV_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (clr) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
      cnt_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
      capt_q  <= '0;
      irq     <= 1'b0;
      wake    <= 1'b0;
      trig    <= 1'b0;
    end else begin
      if (wr_ctrl)                       ctrl_q    <= ctrl_wr;
      else if (ovf_evt && !ctrl_q.ar)    ctrl_q.st <= 1'b0;
      if (wr_ien)   ien_q   <= bus_wdata[EV_W-1:0];
      if (wr_wen)   wen_q   <= bus_wdata[EV_W-1:0];
      if (wr_load)  load_q  <= bus_wdata;
      if (wr_match) match_q <= bus_wdata;
      if (cap_evt)  capt_q  <= cnt_q;
      cnt_q  <= cnt_nx;
      stat_q <= (stat_q & ~clr_mask) | ev_now;
      irq    <= |(stat_q & ien_q);
      wake   <= |(stat_q & wen_q);
      trig   <= ((ctrl_q.trg == TRG_OVF)  && ovf_evt) ||
                ((ctrl_q.trg == TRG_BOTH) && (ovf_evt || mat_evt));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= CW'(ctrl_q);
        A_SYSCFG: bus_rdata <= CW'({srst_q, 1'b0});
        A_RSTAT:  bus_rdata <= CW'(!srst_q);
        A_STATUS: bus_rdata <= CW'(stat_q);
        A_IRQEN:  bus_rdata <= CW'(ien_q);
        A_WAKEEN: bus_rdata <= CW'(wen_q);
        A_COUNT:  bus_rdata <= cnt_q;
        A_LOAD:   bus_rdata <= load_q;
        A_MATCH:  bus_rdata <= match_q;
        A_CAPT:   bus_rdata <= capt_q;
        A_POSINC: bus_rdata <= pos_q;
        A_NEGINC: bus_rdata <= neg_q;
        A_ACCUM:  bus_rdata <= acc_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R4: one-shot overflow halts the timer at zero
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (clr)
    (ovf_evt && !ctrl_q.ar && !wr_ctrl) |=> (!ctrl_q.st && cnt_q == '0));

  // R6: a match event leaves the counter at the compare value with the flag set
  p_match_flag_r6: assert property (@(posedge clk) disable iff (clr)
    mat_evt |=> (stat_q[EV_MATCH] && cnt_q == match_q));

  // R7: a capture event latches the counter it saw
  p_capt_latch_r7: assert property (@(posedge clk) disable iff (clr)
    cap_evt |=> (stat_q[EV_CAPT] && capt_q == $past(cnt_q)));

  // R8: writing one to a quiet overflow flag clears it
  p_w1c_ovf_r8: assert property (@(posedge clk) disable iff (clr)
    (wr_stat && bus_wdata[EV_OVF] && !ovf_evt) |=> !stat_q[EV_OVF]);

  // R9: the soft reset lasts one clock and empties the control state
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (!srst_q && ctrl_q == '0 && stat_q == '0));
endmodule

// File: tb/gp_tick_timer_test.sv
module gp_tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 0, A_SYSCFG = 1, A_RSTAT = 2, A_STATUS = 3,
    A_IRQEN = 4, A_WAKEEN = 5, A_COUNT = 6, A_LOAD = 7, A_MATCH = 8,
    A_CAPT = 9, A_POSINC = 10, A_NEGINC = 11;
  localparam logic [31:0] C_ST = 32'h1, C_AR = 32'h2, C_PRE = 32'h20,
    C_CMP = 32'h40, C_TRG01 = 32'h400, C_TRG10 = 32'h800;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, cap_in = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, rdata, rdata_p;
  logic irq, wake, trig, irq_p, wake_p, trig_p;
  int n_run = 0, n_fail = 0;
  int ivl[16];

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_tick_timer #(.CW(32), .ACC_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .cap_in(cap_in),
    .irq(irq), .wake(wake), .trig(trig));

  gp_tick_timer #(.CW(32), .ACC_EN(1'b0)) uut_plain (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_p), .cap_in(cap_in),
    .irq(irq_p), .wake(wake_p), .trig(trig_p));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v, output logic [31:0] vp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = rdata; vp = rdata_p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // record k intervals between trig pulses of one instance
  task automatic measure(input int k, input bit plain, output bit ok);
    int last = -1, got = 0, cyc = 0;
    while (got < k + 1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (plain ? trig_p : trig) begin
        if (last >= 0) ivl[got-1] = cyc - last;
        last = cyc;
        got++;
      end
    end
    ok = (got == k + 1);
  endtask

  task automatic program_run(input int n, input logic [31:0] pos, input logic [31:0] neg,
                             input logic [31:0] ctl);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'h0 - 32'(n));
    wr(A_COUNT, 32'h0 - 32'(n));
    wr(A_POSINC, pos);
    wr(A_NEGINC, neg);
    wr(4'd12, 32'h0);
    wr(A_CTRL, ctl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, vp;
    bit ok;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v, vp);   check("R1 ctrl", v, 0);
    rd(A_STATUS, v, vp); check("R1 status", v, 0);
    rd(A_COUNT, v, vp);  check("R1 count", v, 0);
    rd(A_RSTAT, v, vp);  check("R1 reset done", v, 1);
    check("R1 outputs", {29'd0, irq, wake, trig}, 0);

    // R2 control field mask
    wr(A_CTRL, 32'hFFFF_FF7E);
    rd(A_CTRL, v, vp); check("R2 ctrl mask", v, 32'h0000_0F7E);
    wr(A_CTRL, 32'h0);

    // R3 period sweep, no correction (both increments zero)
    for (int n = 1; n <= 6; n++) begin
      program_run(n, 0, 0, C_ST | C_AR | C_TRG01);
      measure(4, 1'b0, ok);
      check("R3 overflow seen", 32'(ok), 1);
      for (int i = 0; i < 4; i++) check($sformatf("R3 period N=%0d", n), ivl[i], n);
    end

    // R10 correction sequences vs arithmetic model, R11 plain instance
    for (int c = 0; c < 5; c++) begin
      int n; longint pos, neg, acc;
      case (c)
        0: begin n = 4;  pos = 3;      neg = -1;      end
        1: begin n = 2;  pos = 1;      neg = -2;      end
        2: begin n = 32; pos = 232000; neg = -768000; end
        3: begin n = 3;  pos = 5;      neg = 5;       end
        default: begin n = 3; pos = -1; neg = -1;     end
      endcase
      program_run(n, 32'(pos), 32'(neg), C_ST | C_AR | C_TRG01);
      measure(10, 1'b0, ok);
      check("R10 overflow seen", 32'(ok), 1);
      acc = 0;
      for (int i = 0; i < 10; i++) begin
        int exp_p;
        if (acc + neg >= 0) begin acc += neg; exp_p = n;     end
        else                begin acc += pos; exp_p = n + 1; end
        check($sformatf("R10 cfg%0d period %0d", c, i), ivl[i], exp_p);
      end
      measure(6, 1'b1, ok);
      check("R11 overflow seen", 32'(ok), 1);
      for (int i = 0; i < 6; i++) check($sformatf("R11 cfg%0d period", c), ivl[i], n);
      rd(A_POSINC, v, vp);
      check("R11 pos ignored", vp, 0);
      check("R10 pos stored", v, 32'(pos));
      rd(A_NEGINC, v, vp);
      check("R11 neg ignored", vp, 0);
    end

    // R5 prescaler sweep
    for (int p = 0; p < 8; p++) begin
      program_run(3, 0, 0, C_ST | C_AR | C_TRG01 | C_PRE | (32'(p) << 2));
      measure(3, 1'b0, ok);
      check("R5 overflow seen", 32'(ok), 1);
      for (int i = 0; i < 3; i++) check($sformatf("R5 p=%0d", p), ivl[i], 3 * (2 << p));
    end

    // R12 trigger modes
    program_run(8, 0, 0, C_ST | C_AR | C_CMP | C_TRG10);
    wr(A_MATCH, 32'h0 - 32'd8 + 32'd3);
    idle(20);
    begin
      int cnt = 0;
      for (int i = 0; i < 16; i++) begin @(negedge clk); if (trig) cnt++; end
      check("R12 mode10 pulses", cnt, 4);
    end
    wr(A_CTRL, C_ST | C_AR | C_TRG01);
    idle(4);
    begin
      int cnt = 0;
      for (int i = 0; i < 16; i++) begin @(negedge clk); if (trig) cnt++; end
      check("R12 mode01 pulses", cnt, 2);
    end

    // R4 one-shot
    program_run(4, 0, 0, C_ST);
    wr(A_STATUS, 32'h7);
    idle(12);
    rd(A_CTRL, v, vp);   check("R4 start cleared", v[0], 0);
    rd(A_COUNT, v, vp);  check("R4 count zero", v, 0);
    rd(A_STATUS, v, vp); check("R4 ovf flag", v[1], 1);

    // R6 compare
    wr(A_STATUS, 32'h7);
    wr(A_MATCH, 32'd105);
    wr(A_COUNT, 32'd100);
    wr(A_CTRL, C_ST);
    idle(12);
    rd(A_STATUS, v, vp); check("R6 no match when disabled", v[0], 0);
    wr(A_CTRL, 32'h0);
    wr(A_COUNT, 32'd100);
    wr(A_CTRL, C_ST | C_CMP);
    rd(A_STATUS, v, vp); check("R6 not yet matched", v[0], 0);
    idle(10);
    rd(A_STATUS, v, vp); check("R6 match flag", v[0], 1);

    // R8 write-one-to-clear, irq and wake levels
    wr(A_CTRL, 32'h0);
    wr(A_STATUS, 32'h7);
    rd(A_STATUS, v, vp); check("R8 cleared all", v, 0);
    wr(A_LOAD, 32'h0 - 32'd4);
    wr(A_COUNT, 32'h0 - 32'd4);
    wr(A_MATCH, 32'h0 - 32'd3);
    wr(A_CTRL, C_ST | C_CMP);
    idle(10);
    rd(A_STATUS, v, vp); check("R8 two flags", v, 3);
    check("R8 irq masked", irq, 0);
    wr(A_IRQEN, 32'h2);
    idle(2);
    check("R8 irq on", irq, 1);
    wr(A_STATUS, 32'h1);
    rd(A_STATUS, v, vp); check("R8 partial clear", v, 2);
    check("R8 irq still on", irq, 1);
    wr(A_WAKEEN, 32'h2);
    idle(2);
    check("R8 wake on", wake, 1);
    wr(A_STATUS, 32'h2);
    idle(2);
    rd(A_STATUS, v, vp); check("R8 fully clear", v, 0);
    check("R8 irq off", irq, 0);
    check("R8 wake off", wake, 0);

    // R7 capture mode x edge sweep, counter stopped
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        logic [31:0] cv;
        logic expf;
        cv = 32'h1234_0000 + 32'(m * 2 + e);
        cap_in = (e == 0) ? 1'b0 : 1'b1;
        wr(A_CTRL, 32'h0);
        wr(A_COUNT, cv);
        idle(5);
        wr(A_CTRL, 32'(m) << 8);
        wr(A_STATUS, 32'h7);
        @(negedge clk);
        cap_in = ~cap_in;
        idle(6);
        expf = (e == 0) ? m[0] : m[1];
        rd(A_STATUS, v, vp);
        check($sformatf("R7 mode%0d edge%0d flag", m, e), v[2], expf);
        if (expf) begin
          rd(A_CAPT, v, vp);
          check($sformatf("R7 mode%0d value", m), v, cv);
        end
      end
    end

    // R9 soft reset
    wr(A_LOAD, 32'hABCD);
    wr(A_CTRL, 32'h22);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_SYSCFG; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_RSTAT;
    @(negedge clk);
    check("R9 busy", rdata, 0);
    rd(A_RSTAT, v, vp);  check("R9 done", v, 1);
    rd(A_SYSCFG, v, vp); check("R9 self clear", v, 0);
    rd(A_LOAD, v, vp);   check("R9 load reset", v, 0);
    rd(A_CTRL, v, vp);   check("R9 ctrl reset", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule